// File: doc/BRIEF.md
# Approximate Unsigned Multiplier (4x4 core, 8x8 composition)

This block multiplies two unsigned operands combinationally and gives up exactness in the low-order columns to save gates. The 4x4 core forms its sixteen partial products with AND gates. The five low product bits are the OR of their column's partial products. The top three bits come from two half adders. In the first of these, the sum XOR is replaced by an OR.

The top wraps four 4x4 cores into an 8x8 multiplier with a 16-bit result. The high-by-high sub-product always uses the exact core. The other three use the approximate core. The sub-products are shifted and added exactly. A single parameter forces every core to the exact variant, so one design serves as both the low-power and the accurate multiplier.

Top module: `apx_mul8`

## Requirements
- R1: Each partial product is a[i] AND b[j]. In approximate mode, product bits 0..4 of a 4x4 core are the OR of all partial products whose i+j equals the bit index.
- R2: Bit 5 of an approximate 4x4 core is a[3]b[2] OR a[2]b[3].
- R3: The column-5 carry is a[3]b[2] AND a[2]b[3]. Bit 6 is a[3]b[3] XOR that carry, and bit 7 is a[3]b[3] AND that carry.
- R4: An approximate 4x4 core returns the exact product whenever either operand has at most one bit set.
- R5: The exact 4x4 core returns a*b for all 256 operand pairs.
- R6: The 8x8 result equals P_LL + (P_HL << 4) + (P_LH << 4) + (P_HH << 8), computed exactly in 16 bits. Here P_HH = exact(a[7:4]*b[7:4]), and P_LL, P_HL, P_LH are approximate products of the corresponding nibble pairs (L = bits 3:0, H = bits 7:4).
- R7: With EXACT_ALL = 1, the 16-bit result equals a*b for all operand pairs.
- R8: In approximate mode, no carry from columns 0..4 reaches column 5 or above. For example, 3*3 gives 7 rather than 9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | 8 | Unsigned multiplicand |
| opb_i | input | 8 | Unsigned multiplier |
| prod_o | output | 16 | Product, approximate or exact per EXACT_ALL |

## Verification
The bench targets the columns where the approximation departs from arithmetic. 3*3 exposes a design that lets low-column carries ripple upward, because it would return 9 instead of 7. 12*12 sets both column-5 terms: a design with a true XOR in bit 5 would give 144 instead of 176, and one that dropped the column-5 carry would misplace bits 6 and 7. Operands confined to the high nibbles expose a design that wired the high-by-high sub-product to the approximate core or used the wrong shift. The exhaustive sweeps in both modes expose a mis-indexed partial product wherever it hides.

// File: rtl/apx_mul_pkg.sv
package apx_mul_pkg;
  localparam int NIB      = 4;
  localparam int PW       = 2 * NIB;
  localparam int LOW_COLS = PW - 3;  // columns handled by plain OR

  // pp[i][j] = a[i] & b[j]; row i is pp[i]
  typedef logic [NIB-1:0][NIB-1:0] pp_t;

  // OR of every partial product that lands in column col
  function automatic logic col_any(input pp_t pp, input int col);
    logic r;
    r = 1'b0;
    for (int i = 0; i < NIB; i++) begin
      for (int j = 0; j < NIB; j++) begin
        if (i + j == col) r = r | pp[i][j];
      end
    end
    return r;
  endfunction

  // Exact shift-and-add of the partial-product rows
  function automatic logic [PW-1:0] sum_rows(input pp_t pp);
    logic [PW-1:0] acc;
    acc = '0;
    for (int i = 0; i < NIB; i++) begin
      acc = acc + (PW'(pp[i]) << i);
    end
    return acc;
  endfunction
endpackage

// File: rtl/apx_pp_gen.sv
module apx_pp_gen
  import apx_mul_pkg::*;
(
  input  logic [NIB-1:0] a_i,
  input  logic [NIB-1:0] b_i,
  output pp_t            pp_o
);
  for (genvar i = 0; i < NIB; i++) begin : g_row
    for (genvar j = 0; j < NIB; j++) begin : g_col
      assign pp_o[i][j] = a_i[i] & b_i[j];
    end
  end

  // R1: a partial product can only be set when both operand bits are set
  always_comb begin
    p_pp_needs_bits_r1: assert ((pp_o == '0) || (a_i != '0 && b_i != '0))
      else $error("pp set with a zero operand");
  end
endmodule

// File: rtl/apx_mul4.sv
module apx_mul4
  import apx_mul_pkg::*;
#(
  parameter bit EXACT = 1'b0
) (
  input  logic [NIB-1:0] a_i,
  input  logic [NIB-1:0] b_i,
  output logic [PW-1:0]  y_o
);
  pp_t pp;

  apx_pp_gen u_pp (
    .a_i  (a_i),
    .b_i  (b_i),
    .pp_o (pp)
  );

  if (EXACT) begin : g_exact
    assign y_o = sum_rows(pp);

    // R5: exact core matches the arithmetic product
    always_comb begin
      p_exact_product_r5: assert (y_o == PW'(a_i) * PW'(b_i))
        else $error("exact core mismatch");
    end
  end else begin : g_approx
    logic c5;   // column-5 half-adder carry
    logic hi6;  // the lone partial product of column 6

    for (genvar k = 0; k < LOW_COLS; k++) begin : g_low
      assign y_o[k] = col_any(pp, k);
    end

    assign c5     = pp[3][2] & pp[2][3];
    assign y_o[5] = pp[3][2] | pp[2][3];
    assign hi6    = pp[3][3];
    assign y_o[6] = hi6 ^ c5;
    assign y_o[7] = hi6 & c5;

    always_comb begin
      // R4: a single-bit operand leaves every column with at most one term
      if ($countones(a_i) <= 1 || $countones(b_i) <= 1)
        p_single_bit_exact_r4: assert (y_o == PW'(a_i) * PW'(b_i))
          else $error("single-bit operand not exact");
      // R3: the top bit needs the whole upper 2x2 corner of both operands
      if (y_o[7])
        p_top_bit_corner_r3: assert (a_i[3] && a_i[2] && b_i[3] && b_i[2])
          else $error("bit 7 without upper corner");
      // R8: with the upper two bits of one operand clear, bits 5..7 stay clear
      if (a_i[3:2] == 2'b00)
        p_no_carry_up_r8: assert (y_o[7:5] == 3'b000)
          else $error("low-column carry leaked upward");
    end
  end
endmodule

// File: rtl/apx_mul8.sv
module apx_mul8
  import apx_mul_pkg::*;
#(
  parameter bit EXACT_ALL = 1'b0
) (
  input  logic [2*NIB-1:0] opa_i,
  input  logic [2*NIB-1:0] opb_i,
  output logic [4*NIB-1:0] prod_o
);
  localparam int OW   = 2 * NIB;
  localparam int RW   = 4 * NIB;
  localparam int NSUB = 4;

  // sub-product q: bit0 selects a nibble, bit1 selects b nibble (0 = low)
  logic [PW-1:0] sub_p [NSUB];
  logic [RW-1:0] sub_w [NSUB];

  for (genvar q = 0; q < NSUB; q++) begin : g_sub
    localparam int  AH    = q % 2;
    localparam int  BH    = q / 2;
    localparam bit  IS_EX = EXACT_ALL || (AH == 1 && BH == 1);
    localparam int  SH    = NIB * (AH + BH);

    apx_mul4 #(.EXACT(IS_EX)) u_core (
      .a_i (opa_i[AH*NIB +: NIB]),
      .b_i (opb_i[BH*NIB +: NIB]),
      .y_o (sub_p[q])
    );

    assign sub_w[q] = RW'(sub_p[q]) << SH;
  end

  assign prod_o = sub_w[0] + sub_w[1] + sub_w[2] + sub_w[3];

  always_comb begin
    // R6: with both low nibbles clear only the exact high-by-high term remains
    if (opa_i[NIB-1:0] == '0 && opb_i[NIB-1:0] == '0)
      p_hh_exact_r6: assert (prod_o == (RW'(opa_i) * RW'(opb_i)))
        else $error("high-by-high term not exact");
    // R7: all-exact build matches arithmetic everywhere
    if (EXACT_ALL)
      p_all_exact_r7: assert (prod_o == RW'(opa_i) * RW'(opb_i))
        else $error("exact build mismatch");
  end
endmodule

// File: tb/apx_mul8_bench.sv
module apx_mul8_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [7:0]  a, b;
  logic [15:0] p_apx, p_ex;
  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  apx_mul8 #(.EXACT_ALL(1'b0)) u_apx_mul8 (.opa_i(a), .opb_i(b), .prod_o(p_apx));
  apx_mul8 #(.EXACT_ALL(1'b1)) u_apx_mul8_exact (.opa_i(a), .opb_i(b), .prod_o(p_ex));

  // {a, b, expected approximate product}
  localparam int NV = 10;
  localparam logic [31:0] VEC [NV] = '{
    {8'h00, 8'h00, 16'd0},      // reset-like zero
    {8'h03, 8'h03, 16'd7},      // R8 carries dropped
    {8'h0C, 8'h0C, 16'd176},    // R3 both column-5 terms
    {8'h0E, 8'h0B, 16'd126},    // R2 single column-5 term
    {8'h05, 8'h06, 16'd30},     // R1 no overlap, exact
    {8'h0A, 8'h0A, 16'd84},     // R1 overlap in column 2/4
    {8'h08, 8'h08, 16'd64},     // R4 single-bit operands
    {8'hFF, 8'hFF, 16'd63903},  // R6 all four sub-products
    {8'h33, 8'h33, 16'd2535},   // R6 mixed
    {8'hF0, 8'hF0, 16'd57600}   // R6 high-by-high exact
  };

  // bench model: column counts instead of gate expressions
  function automatic logic [7:0] model4(input logic [3:0] x, input logic [3:0] y);
    int cnt [8];
    logic [7:0] r;
    int s;
    for (int k = 0; k < 8; k++) cnt[k] = 0;
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++)
        if (x[i] && y[j]) cnt[i+j]++;
    r = '0;
    for (int k = 0; k < 6; k++) r[k] = (cnt[k] > 0);
    s = cnt[6] + ((cnt[5] == 2) ? 1 : 0);
    r[6] = s[0];
    r[7] = s[1];
    return r;
  endfunction

  function automatic logic [15:0] model8(input logic [7:0] x, input logic [7:0] y);
    int t;
    t = int'(model4(x[3:0], y[3:0]))
      + (int'(model4(x[7:4], y[3:0])) * 16)
      + (int'(model4(x[3:0], y[7:4])) * 16)
      + (int'(x[7:4]) * int'(y[7:4]) * 256);
    return t[15:0];
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s a=%0d b=%0d actual=%0d expected=%0d", req, a, b, act, exp);
    end
  endtask

  task automatic apply(input logic [7:0] x, input logic [7:0] y);
    @(negedge clk);
    a = x;
    b = y;
    @(posedge clk);
    #1;
  endtask

  initial begin
    int ed_sum;
    int ed_max;
    int d;
    a = '0;
    b = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // reset state: zero operands give zero in both builds
    apply(8'h00, 8'h00);
    check("R1 zero approx", p_apx, 16'd0);
    check("R7 zero exact", p_ex, 16'd0);

    // vector table
    for (int v = 0; v < NV; v++) begin
      apply(VEC[v][31:24], VEC[v][23:16]);
      check("R6 table", p_apx, VEC[v][15:0]);
      check("R7 table exact", p_ex, 16'(int'(VEC[v][31:24]) * int'(VEC[v][23:16])));
    end

    // R1 R2 R3 R8: exhaustive approximate 4x4 through the low nibbles
    ed_sum = 0;
    ed_max = 0;
    for (int x = 0; x < 16; x++) begin
      for (int y = 0; y < 16; y++) begin
        apply(8'(x), 8'(y));
        check("R1/R2/R3 core", p_apx, {8'h00, model4(4'(x), 4'(y))});
        d = int'(p_apx) - x * y;
        if (d < 0) d = -d;
        ed_sum += d;
        if (d > ed_max) ed_max = d;
        if ($countones(4'(x)) <= 1 || $countones(4'(y)) <= 1)
          check("R4 single bit", p_apx, 16'(x * y));
      end
    end
    $display("[TB] 4x4 error distance: total %0d, max %0d over 256 pairs", ed_sum, ed_max);

    // R5: exact core through the high nibbles
    for (int x = 0; x < 16; x++)
      for (int y = 0; y < 16; y++) begin
        apply(8'(x << 4), 8'(y << 4));
        check("R5 exact core", p_apx, 16'((x * y) << 8));
      end

    // R6 and R7: full 8x8 sweep of both builds
    for (int x = 0; x < 256; x++)
      for (int y = 0; y < 256; y++) begin
        apply(8'(x), 8'(y));
        check("R6 compose", p_apx, model8(8'(x), 8'(y)));
        check("R7 exact", p_ex, 16'(x * y));
      end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (198000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule